// File: doc/BRIEF.md
# Normalising Shift-Subtract Divider

This block divides one unsigned integer by another over several clock cycles and returns the truncated quotient. The operands are 31-bit non-negative values carried on 32-bit ports; bit 31 of each is dropped when the operands are taken in. The remainder is not brought out.

Division runs in two phases. In the first phase the block aligns the denominator: it shifts the denominator left until bit 30 is set. A one-hot unit register starts at 1 and shifts left in the same steps. In the second phase the block works back down. Each cycle it compares the running numerator with the shifted denominator. When the difference is non-negative, it adds the unit to the quotient and keeps the difference as the new numerator. Then the denominator and the unit both shift right. The run ends when the unit reaches zero.

Because a zero denominator can never be aligned, it is caught at start. The block answers it at once with an all-ones quotient and a flag. The latency of a normal division is not fixed: it depends on how many leading zeros the 31-bit denominator has.

Top module: `norm_divider`

## Requirements
- R1: After reset, busy, done, div_zero and quot are all 0.
- R2: For a non-zero 31-bit denominator, quot equals the 31-bit numerator divided by the denominator, truncated toward zero, zero-extended to 32 bits, and is valid in the cycle done is high.
- R3: A start with a zero denominator (bits 30:0 all zero) raises done and div_zero in the cycle after the start edge, with quot all ones, and busy never rises.
- R4: A start seen while busy is high is ignored. The running division finishes with its original operands and its original latency.
- R5: Let L be 30 minus the index of the highest set bit of the 31-bit denominator. Done is high exactly 2L+2 clock edges after the edge that samples start.
- R6: Done is a one-cycle pulse and busy is low while done is high. Busy is high from the edge after an accepted non-zero start until the final step.
- R7: Bit 31 of the numerator and of the denominator has no effect on the result.
- R8: Between done and the next accepted start, quot and div_zero hold their values. A non-zero division clears div_zero.
- R9: A denominator with bit 30 set needs no shifting and completes after 2 edges, with a single subtract step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands (taken only when idle) |
| numer | input | 32 | Numerator, bits 30:0 used |
| denom | input | 32 | Denominator, bits 30:0 used |
| quot | output | 32 | Quotient of the last completed division |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse on completion |
| div_zero | output | 1 | Last completed division had a zero denominator |

## Verification
Two events can land in the same cycle: a new start request and a division that is still running, including its final subtract step. The bench raises start with different operands while busy is high. It checks that the quotient and the completion cycle still match the first operands. It also starts a fresh division in the cycle straight after done, where busy is already low and the request must be taken. The zero-denominator path is run right after a normal result, and a normal run right after it, to judge how the flag and the quotient are held and cleared.

// File: rtl/norm_divider.sv
module norm_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] numer,
  input  logic [W-1:0] denom,
  output logic [W-1:0] quot,
  output logic         busy,
  output logic         done,
  output logic         div_zero
);
  localparam int OW  = W - 1;
  localparam int TOP = OW - 1;

  typedef enum logic [1:0] {S_IDLE, S_NORM, S_SUB} state_t;

  state_t         st;
  logic [OW-1:0]  rem, dsh, unit, qacc, qnext;
  logic [OW:0]    diff;
  logic           ge;

  assign busy  = (st != S_IDLE);
  assign diff  = {1'b0, rem} - {1'b0, dsh};
  assign ge    = ~diff[OW];
  assign qnext = ge ? (qacc | unit) : qacc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      dsh      <= '0;
      unit     <= '0;
      qacc     <= '0;
      quot     <= '0;
      done     <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (denom[OW-1:0] == '0) begin
            quot     <= '1;
            div_zero <= 1'b1;
            done     <= 1'b1;
          end else begin
            rem  <= numer[OW-1:0];
            dsh  <= denom[OW-1:0];
            unit <= {{(OW-1){1'b0}}, 1'b1};
            qacc <= '0;
            st   <= S_NORM;
          end
        end
        S_NORM: begin
          if (dsh[TOP]) st <= S_SUB;
          else begin
            dsh  <= dsh << 1;
            unit <= unit << 1;
          end
        end
        S_SUB: begin
          if (ge) rem <= diff[OW-1:0];
          qacc <= qnext;
          dsh  <= dsh >> 1;
          unit <= unit >> 1;
          if (unit == {{(OW-1){1'b0}}, 1'b1}) begin
            quot     <= {1'b0, qnext};
            div_zero <= 1'b0;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/norm_divider_chk.sv
module norm_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] numer,
  input logic [W-1:0] denom,
  input logic [W-1:0] quot,
  input logic         busy,
  input logic         done,
  input logic         div_zero
);
  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  zero_quot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quot == {W{1'b1}}));
  // R6
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R4
  busy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8
  quot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !$past(start)) |-> ($stable(quot) && $stable(div_zero)));
  // R2
  quot_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> !quot[W-1]);
endmodule

bind norm_divider norm_divider_chk #(.W(W)) u_chk (.*);

// File: tb/tb_norm_divider.sv
`timescale 1ns/1ps
module tb_norm_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] numer = '0;
  logic [31:0] denom = '0;
  logic [31:0] quot;
  logic        busy, done, div_zero;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  norm_divider dut (.*);

  localparam int NV = 11;
  localparam logic [95:0] VEC [NV] = '{
    {32'd100,        32'd7,          32'd14},
    {32'd0,          32'd5,          32'd0},
    {32'd5,          32'd100,        32'd0},
    {32'h7FFFFFFF,   32'd1,          32'h7FFFFFFF},
    {32'h7FFFFFFF,   32'h7FFFFFFF,   32'd1},
    {32'd1000000,    32'd1000,       32'd1000},
    {32'h40000000,   32'h40000000,   32'd1},
    {32'd12345678,   32'd3,          32'd4115226},
    {32'h7FFFFFFF,   32'd2,          32'h3FFFFFFF},
    {32'd99,         32'd99,         32'd1},
    {32'h80000064,   32'h80000007,   32'd14}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lat(input logic [31:0] d);
    int m = 0;
    for (int i = 0; i < 31; i++) if (d[i]) m = i;
    return 2 * (30 - m) + 2;
  endfunction

  task automatic launch(input logic [31:0] n, input logic [31:0] d);
    numer = n; denom = d; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    while (!done && cnt < 200) begin
      @(posedge clk); #1;
      cnt++;
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    #2;
    // R1
    chk(busy == 0 && done == 0 && div_zero == 0 && quot == 0, "R1 reset", {28'd0, busy, done, div_zero, 1'b0} | quot, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][95:64], VEC[v][63:32]);
      // R6
      chk(busy == 1, "R6 busy after start", busy, 1);
      wait_done(cnt);
      // R2 R7
      chk(quot == VEC[v][31:0], (v == NV-1) ? "R7 bit31 ignored" : "R2 quotient", quot, VEC[v][31:0]);
      // R5
      chk(cnt == lat(VEC[v][63:32]), "R5 latency", cnt, lat(VEC[v][63:32]));
      chk(!busy && !div_zero, "R6 busy low at done", {busy, div_zero}, 0);
      @(posedge clk); #1;
      chk(!done, "R6 done pulse", done, 0);
    end

    // R9 bit 30 set: 2 edges
    launch(32'h7FFFFFFF, 32'h50000000);
    wait_done(cnt);
    chk(cnt == 2 && quot == 1, "R9 aligned denom", cnt, 2);

    // R4 start while busy ignored
    launch(32'd100, 32'd7);
    repeat (3) @(posedge clk);
    #1 numer = 32'd50; denom = 32'h40000000; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done(cnt);
    chk(quot == 14, "R4 quotient kept", quot, 14);
    chk(cnt + 4 == lat(32'd7), "R4 latency kept", cnt + 4, lat(32'd7));
    // start in the cycle right after done is accepted
    launch(32'd81, 32'd9);
    wait_done(cnt);
    chk(quot == 9, "R4 start after done", quot, 9);

    // R8 hold
    repeat (5) @(posedge clk); #1;
    chk(quot == 9 && !div_zero && !busy, "R8 hold", quot, 9);

    // R3 zero denominator
    launch(32'd1234, 32'h80000000);
    chk(done && div_zero && quot == 32'hFFFFFFFF && !busy, "R3 zero denom", quot, 32'hFFFFFFFF);
    repeat (4) @(posedge clk); #1;
    chk(div_zero && quot == 32'hFFFFFFFF && !done, "R8 zero hold", quot, 32'hFFFFFFFF);
    launch(32'd20, 32'd4);
    wait_done(cnt);
    chk(quot == 5 && !div_zero, "R8 flag cleared", {div_zero, quot[30:0]}, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule